// File: doc/BRIEF.md
# Secure Wipe Sequencer with Software Arbitration

This block owns a single flash command port and hands it either to software or to a hardware-triggered wipe. In normal operation, software requests pass through to the flash. Each accepted request is granted in the same cycle, and the flash reply comes back to software.

A wipe request locks software out at once. If a software operation is already in flight, the wipe lets it finish first. The wipe then walks every page in ascending order. For each page it erases the page, programs it with a fixed fill pattern and reads it back to compare.

When the last page reads back correctly, the wipe acknowledge is raised and held. Any fault makes the sequencer enter an invalid state and raise a fatal flag. A fault is a flash error during erase, program or read, or a readback that differs from the fill pattern. Both end states are terminal until reset, and software stays denied in both.

Top module: `flash_wipe_seq`

## Requirements
- R1: A software operation accepted before a wipe request completes on the flash port before the wipe issues its first command. The two never drive the port at the same time.
- R2: The wipe covers pages 0 to NUM_PAGES-1 in ascending order, with three commands per page:
  - erase (op 2), then program (op 1) with data FILL, then read (op 0);
  - the page address is the page index shifted left by PAGE_SHIFT;
  - afterwards every wiped address reads FILL, not its prior content.
- R3: `wipe_ack` rises only after the read of the last page returns FILL without error. It then stays high until reset and is never high together with `fatal_err`.
- R4: Software is locked out from the cycle `wipe_req` is first seen until reset:
  - `sw_gnt` stays low;
  - each cycle with `sw_req` high and no grant makes `sw_deny` high in the next cycle;
  - no flash command results from a denied request.
- R5: A flash error on a wipe program command makes `fatal_err` go high the next cycle and stay high until reset. No further flash commands are issued after that, and `wipe_ack` never rises.
- R6: A flash error on a wipe erase or read command, or readback data that differs from FILL, has the same fatal effect as R5.
- R7: Reset clears `wipe_ack`, `fatal_err` and the lockout, so software is granted again. Flash content written by a wipe remains.
- R8: When idle, a software request is granted in the same cycle. Its op (0 read, 1 program, 2 erase), address and data are driven on the flash port until `fl_done`. `sw_done`, `sw_err` and `sw_rdata` mirror `fl_done`, `fl_err` and `fl_rdata` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Software operation request, held until granted |
| sw_op | input | 2 | Software op: 0 read, 1 program, 2 erase |
| sw_addr | input | ADDR_W | Software word address |
| sw_wdata | input | DATA_W | Software program data |
| sw_gnt | output | 1 | Request accepted this cycle |
| sw_done | output | 1 | Software operation finished |
| sw_err | output | 1 | Flash reported an error on the software operation |
| sw_deny | output | 1 | Previous cycle's request refused because of lockout |
| sw_rdata | output | DATA_W | Read data for software |
| wipe_req | input | 1 | Wipe request |
| wipe_ack | output | 1 | Wipe completed and verified |
| fl_req | output | 1 | Flash command valid, held until fl_done |
| fl_op | output | 2 | Flash op: 0 read, 1 program, 2 erase |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash program data |
| fl_done | input | 1 | Flash command finished (one-cycle pulse) |
| fl_err | input | 1 | Flash error, valid with fl_done |
| fl_rdata | input | DATA_W | Flash read data, valid with fl_done |
| fatal_err | output | 1 | Wipe fault, held until reset |

## Verification
The bench builds the block with its defaults: 4 pages, PAGE_SHIFT 4, 8-bit addresses, 16-bit data and fill 16'hC3A5. With these values a full wipe is twelve flash commands. That makes the complete command log small enough to compare entry by entry, including the software program that precedes the first erase. The flash model answers every command two cycles after it is raised, which leaves room to raise a wipe request while a software operation is still open. The model can also fail a program command or flip a read bit on demand, so both fault paths can be reached mid-wipe.

// File: rtl/wipe_pkg.sv
// Shared encodings for the wipe sequencer: flash op codes and FSM states.
package wipe_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } fop_e;

    typedef enum logic [3:0] {
        WS_IDLE    = 4'h0,
        WS_DRAIN   = 4'h1,
        WS_PAGE    = 4'h2,
        WS_ERASE   = 4'h3,
        WS_PROG    = 4'h4,
        WS_CHECK   = 4'h5,
        WS_DONE    = 4'h6,
        WS_INVALID = 4'hF
    } wstate_e;
endpackage

// File: rtl/wipe_sw_port.sv
// Software side of the arbiter: accepts a request while unlocked, holds the
// command until the flash replies, and flags refused requests.
// Assumes sw_req is held until sw_gnt, and that fl_done only pulses for the
// current port owner.
module wipe_sw_port #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [1:0]        sw_op,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    input  logic              locked,
    input  logic              wipe_req,
    input  logic              fl_done,
    output logic              sw_gnt,
    output logic              busy,
    output logic              deny,
    output logic [1:0]        op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    logic accept;

    // Grant only when idle, unlocked and no wipe is arriving this cycle.
    always_comb begin
        accept = sw_req && !busy && !locked && !wipe_req;
        sw_gnt = accept;
    end

    // Hold the accepted command, track ownership and register refusals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            deny    <= 1'b0;
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            deny <= sw_req && !accept && (locked || wipe_req);
            if (accept) begin
                busy    <= 1'b1;
                op_q    <= sw_op;
                addr_q  <= sw_addr;
                wdata_q <= sw_wdata;
            end else if (busy && fl_done) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wipe_fsm.sv
// Wipe state machine: waits for software to drain, then erases, programs
// with FILL and verifies each page in turn. Ends in DONE or INVALID until
// reset. Any state encoding outside the defined set falls into INVALID.
// Assumes fl_done only pulses in response to this FSM's own commands while
// it is in a command state.
module wipe_fsm
    import wipe_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 16,
    parameter int              NUM_PAGES  = 4,
    parameter int              PAGE_SHIFT = 4,
    parameter logic [DATA_W-1:0] FILL     = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_req,
    input  logic              sw_busy,
    input  logic              fl_done,
    input  logic              fl_err,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic              locked,
    output logic              wipe_ack,
    output logic              fatal_err
);
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

    wstate_e           state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic              page_inc;

    // Next-state decision for the wipe walk.
    always_comb begin
        state_d  = state_q;
        page_inc = 1'b0;
        case (state_q)
            WS_IDLE:    if (wipe_req) state_d = WS_DRAIN;
            WS_DRAIN:   if (!sw_busy) state_d = WS_PAGE;
            WS_PAGE:    state_d = WS_ERASE;
            WS_ERASE:   if (fl_done) state_d = fl_err ? WS_INVALID : WS_PROG;
            WS_PROG:    if (fl_done) state_d = fl_err ? WS_INVALID : WS_CHECK;
            WS_CHECK: begin
                if (fl_done) begin
                    if (fl_err || (fl_rdata != FILL)) begin
                        state_d = WS_INVALID;
                    end else if (page_q == LAST_PAGE) begin
                        state_d = WS_DONE;
                    end else begin
                        state_d  = WS_PAGE;
                        page_inc = 1'b1;
                    end
                end
            end
            WS_DONE:    state_d = WS_DONE;
            WS_INVALID: state_d = WS_INVALID;
            default:    state_d = WS_INVALID;
        endcase
    end

    // State and page-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            page_q  <= '0;
        end else begin
            state_q <= state_d;
            if (page_inc) page_q <= page_q + 1'b1;
        end
    end

    // Command and status outputs decoded from the current state.
    always_comb begin
        cmd_req   = (state_q == WS_ERASE) || (state_q == WS_PROG) || (state_q == WS_CHECK);
        cmd_op    = OP_READ;
        if (state_q == WS_ERASE) cmd_op = OP_ERASE;
        if (state_q == WS_PROG)  cmd_op = OP_PROG;
        cmd_addr  = ADDR_W'(page_q) << PAGE_SHIFT;
        cmd_wdata = FILL;
        locked    = (state_q != WS_IDLE);
        wipe_ack  = (state_q == WS_DONE);
        fatal_err = (state_q == WS_INVALID);
    end
endmodule

// File: rtl/wipe_cmd_mux.sv
// Flash port steering: software owns the port while busy, otherwise the
// wipe FSM does. Routes the flash reply back to software.
// Assumes the two owners are never active together.
module wipe_cmd_mux #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              sw_busy,
    input  logic [1:0]        sw_op_q,
    input  logic [ADDR_W-1:0] sw_addr_q,
    input  logic [DATA_W-1:0] sw_wdata_q,
    input  logic              wp_req,
    input  logic [1:0]        wp_op,
    input  logic [ADDR_W-1:0] wp_addr,
    input  logic [DATA_W-1:0] wp_wdata,
    input  logic              fl_done,
    input  logic              fl_err,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    output logic              sw_done,
    output logic              sw_err,
    output logic [DATA_W-1:0] sw_rdata
);
    // Select the command source and return the reply.
    always_comb begin
        if (sw_busy) begin
            fl_req   = 1'b1;
            fl_op    = sw_op_q;
            fl_addr  = sw_addr_q;
            fl_wdata = sw_wdata_q;
        end else begin
            fl_req   = wp_req;
            fl_op    = wp_op;
            fl_addr  = wp_addr;
            fl_wdata = wp_wdata;
        end
        sw_done  = sw_busy && fl_done;
        sw_err   = sw_busy && fl_err;
        sw_rdata = fl_rdata;
    end
endmodule

// File: rtl/flash_wipe_seq.sv
// Top of the wipe sequencer: one flash command port shared between
// software requests and a hardware wipe with permanent lockout.
// Assumes a flash that holds off fl_done for at least one cycle after fl_req.
module flash_wipe_seq #(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 16,
    parameter int              NUM_PAGES  = 4,
    parameter int              PAGE_SHIFT = 4,
    parameter logic [DATA_W-1:0] FILL     = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic [1:0]        sw_op,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [DATA_W-1:0] sw_wdata,
    output logic              sw_gnt,
    output logic              sw_done,
    output logic              sw_err,
    output logic              sw_deny,
    output logic [DATA_W-1:0] sw_rdata,
    input  logic              wipe_req,
    output logic              wipe_ack,
    output logic              fl_req,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_done,
    input  logic              fl_err,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              fatal_err
);
    logic              sw_busy;
    logic              locked;
    logic [1:0]        sw_op_q;
    logic [ADDR_W-1:0] sw_addr_q;
    logic [DATA_W-1:0] sw_wdata_q;
    logic              wipe_cmd_req;
    logic [1:0]        wipe_cmd_op;
    logic [ADDR_W-1:0] wipe_cmd_addr;
    logic [DATA_W-1:0] wipe_cmd_wdata;

    wipe_sw_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req   (sw_req),
        .sw_op    (sw_op),
        .sw_addr  (sw_addr),
        .sw_wdata (sw_wdata),
        .locked   (locked),
        .wipe_req (wipe_req),
        .fl_done  (fl_done),
        .sw_gnt   (sw_gnt),
        .busy     (sw_busy),
        .deny     (sw_deny),
        .op_q     (sw_op_q),
        .addr_q   (sw_addr_q),
        .wdata_q  (sw_wdata_q)
    );

    wipe_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAGES(NUM_PAGES),
        .PAGE_SHIFT(PAGE_SHIFT), .FILL(FILL)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_req  (wipe_req),
        .sw_busy   (sw_busy),
        .fl_done   (fl_done),
        .fl_err    (fl_err),
        .fl_rdata  (fl_rdata),
        .cmd_req   (wipe_cmd_req),
        .cmd_op    (wipe_cmd_op),
        .cmd_addr  (wipe_cmd_addr),
        .cmd_wdata (wipe_cmd_wdata),
        .locked    (locked),
        .wipe_ack  (wipe_ack),
        .fatal_err (fatal_err)
    );

    wipe_cmd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .sw_busy    (sw_busy),
        .sw_op_q    (sw_op_q),
        .sw_addr_q  (sw_addr_q),
        .sw_wdata_q (sw_wdata_q),
        .wp_req     (wipe_cmd_req),
        .wp_op      (wipe_cmd_op),
        .wp_addr    (wipe_cmd_addr),
        .wp_wdata   (wipe_cmd_wdata),
        .fl_done    (fl_done),
        .fl_err     (fl_err),
        .fl_rdata   (fl_rdata),
        .fl_req     (fl_req),
        .fl_op      (fl_op),
        .fl_addr    (fl_addr),
        .fl_wdata   (fl_wdata),
        .sw_done    (sw_done),
        .sw_err     (sw_err),
        .sw_rdata   (sw_rdata)
    );
endmodule

// File: rtl/flash_wipe_seq_chk.sv
// Property checker for flash_wipe_seq, attached by bind below.
// Assumes sw_busy and wipe_cmd_req are the ownership signals inside the top.
module flash_wipe_seq_chk #(
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] FILL = 16'hC3A5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_gnt,
    input logic              wipe_req,
    input logic              wipe_ack,
    input logic              fatal_err,
    input logic              fl_req,
    input logic [1:0]        fl_op,
    input logic [DATA_W-1:0] fl_wdata,
    input logic              sw_busy,
    input logic              wipe_cmd_req
);
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_busy && wipe_cmd_req)); // R1
    AST_FILL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_cmd_req && fl_op == 2'd1) |-> (fl_wdata == FILL)); // R2
    AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wipe_ack && fatal_err)); // R3
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_ack |=> wipe_ack); // R3
    AST_LOCK_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_req || wipe_ack || fatal_err) |-> !sw_gnt); // R4
    AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |=> fatal_err); // R5
    AST_FATAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err |-> !fl_req); // R5
endmodule

bind flash_wipe_seq flash_wipe_seq_chk #(.DATA_W(DATA_W), .FILL(FILL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_gnt       (sw_gnt),
    .wipe_req     (wipe_req),
    .wipe_ack     (wipe_ack),
    .fatal_err    (fatal_err),
    .fl_req       (fl_req),
    .fl_op        (fl_op),
    .fl_wdata     (fl_wdata),
    .sw_busy      (sw_busy),
    .wipe_cmd_req (wipe_cmd_req)
);

// File: tb/flash_wipe_seq_tb.sv
module flash_wipe_seq_tb;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NUM_PAGES = 4;
    localparam int PAGE_SHIFT = 4;
    localparam logic [15:0] FILL = 16'hC3A5;

    // {op, addr, wdata, expected read data}
    localparam int NV = 8;
    localparam logic [41:0] VEC [NV] = '{
        {2'd2, 8'h40, 16'h0000, 16'h0000},
        {2'd1, 8'h40, 16'h1234, 16'h0000},
        {2'd0, 8'h40, 16'h0000, 16'h1234},
        {2'd1, 8'h40, 16'hFF00, 16'h0000},
        {2'd0, 8'h40, 16'h0000, 16'h1200},
        {2'd0, 8'h41, 16'h0000, 16'h5A41},
        {2'd2, 8'h41, 16'h0000, 16'h0000},
        {2'd0, 8'h41, 16'h0000, 16'hFFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_req = 1'b0;
    logic [1:0] sw_op = 2'd0;
    logic [7:0] sw_addr = 8'd0;
    logic [15:0] sw_wdata = 16'd0;
    logic sw_gnt, sw_done, sw_err, sw_deny;
    logic [15:0] sw_rdata;
    logic wipe_req = 1'b0;
    logic wipe_ack, fl_req, fatal_err;
    logic [1:0] fl_op;
    logic [7:0] fl_addr;
    logic [15:0] fl_wdata;
    logic fl_done = 1'b0;
    logic fl_err = 1'b0;
    logic [15:0] fl_rdata = 16'd0;

    int n_chk = 0;
    int n_err = 0;
    logic prog_fault = 1'b0;
    logic bad_read = 1'b0;
    logic [15:0] mem [256];
    logic [1:0] log_op [32];
    logic [7:0] log_addr [32];
    int log_n = 0;
    int fl_cnt = 0;

    always #10 clk = ~clk;

    flash_wipe_seq u_dut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_op(sw_op), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_gnt(sw_gnt), .sw_done(sw_done), .sw_err(sw_err),
        .sw_deny(sw_deny), .sw_rdata(sw_rdata), .wipe_req(wipe_req), .wipe_ack(wipe_ack),
        .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_done(fl_done), .fl_err(fl_err), .fl_rdata(fl_rdata), .fatal_err(fatal_err)
    );

    // Flash model: replies two cycles after a command is raised, logs commands.
    always @(posedge clk) begin
        if (!rst_n) begin
            fl_done <= 1'b0; fl_err <= 1'b0; fl_cnt <= 0; log_n <= 0;
        end else if (fl_done) begin
            fl_done <= 1'b0; fl_err <= 1'b0; fl_cnt <= 0;
        end else if (fl_req) begin
            if (fl_cnt == 1) begin
                fl_done <= 1'b1;
                fl_err  <= 1'b0;
                case (fl_op)
                    2'd0: fl_rdata <= bad_read ? (mem[fl_addr] ^ 16'h0001) : mem[fl_addr];
                    2'd1: if (prog_fault) fl_err <= 1'b1;
                          else mem[fl_addr] <= mem[fl_addr] & fl_wdata;
                    2'd2: mem[fl_addr] <= 16'hFFFF;
                    default: fl_err <= 1'b1;
                endcase
                log_op[log_n]   <= fl_op;
                log_addr[log_n] <= fl_addr;
                if (log_n < 31) log_n <= log_n + 1;
            end else begin
                fl_cnt <= fl_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sw_req = 1'b0; wipe_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue one software op; returns read data and error.
    task automatic sw_cmd(input logic [1:0] op, input logic [7:0] a, input logic [15:0] d,
                          output logic [15:0] rd, output logic er);
        int guard = 0;
        @(negedge clk);
        sw_req = 1'b1; sw_op = op; sw_addr = a; sw_wdata = d;
        #1;
        while (!sw_gnt && guard < 50) begin @(negedge clk); #1; guard++; end
        @(negedge clk);
        sw_req = 1'b0;
        guard = 0;
        while (!sw_done && guard < 50) begin @(negedge clk); guard++; end
        rd = sw_rdata; er = sw_err;
    endtask

    task automatic wait_end();
        int guard = 0;
        while (!wipe_ack && !fatal_err && guard < 500) begin @(negedge clk); guard++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic er;
        for (int i = 0; i < 256; i++) mem[i] = 16'h5A00 | 16'(i);

        // Reset state
        repeat (2) @(negedge clk);
        chk(!wipe_ack && !fatal_err && !fl_req && !sw_gnt, "R7 reset outputs",
            {wipe_ack, fatal_err, fl_req, sw_gnt}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: software pass-through, table-driven
        for (int v = 0; v < NV; v++) begin
            sw_cmd(VEC[v][41:40], VEC[v][39:32], VEC[v][31:16], rd, er);
            chk(er == 1'b0, "R8 sw error flag", er, 0);
            if (VEC[v][41:40] == 2'd0)
                chk(rd == VEC[v][15:0], "R8 sw read data", rd, VEC[v][15:0]);
        end

        // R1/R2/R3/R4: wipe requested while a software program is open
        do_reset();
        @(negedge clk);
        sw_req = 1'b1; sw_op = 2'd1; sw_addr = 8'h33; sw_wdata = 16'h0F0F;
        #1;
        chk(sw_gnt == 1'b1, "R8 idle grant", sw_gnt, 1);
        @(negedge clk);
        sw_req = 1'b1; sw_op = 2'd0; sw_addr = 8'h00;
        wipe_req = 1'b1;
        #1;
        chk(sw_gnt == 1'b0, "R4 no grant on wipe", sw_gnt, 0);
        @(negedge clk);
        chk(sw_deny == 1'b1, "R4 deny pulse", sw_deny, 1);
        sw_req = 1'b0;
        wait_end();
        chk(wipe_ack == 1'b1 && fatal_err == 1'b0, "R3 wipe ack", {wipe_ack, fatal_err}, 2'b10);
        chk(log_n == 1 + 3 * NUM_PAGES, "R3 ack after last verify", log_n, 1 + 3 * NUM_PAGES);
        chk(log_op[0] == 2'd1 && log_addr[0] == 8'h33, "R1 sw op first", {log_op[0], log_addr[0]}, {2'd1, 8'h33});
        for (int p = 0; p < NUM_PAGES; p++) begin
            logic [7:0] pa;
            pa = 8'(p << PAGE_SHIFT);
            chk(log_op[1+3*p] == 2'd2 && log_addr[1+3*p] == pa, "R2 erase order",
                {log_op[1+3*p], log_addr[1+3*p]}, {2'd2, pa});
            chk(log_op[2+3*p] == 2'd1 && log_addr[2+3*p] == pa, "R2 program order",
                {log_op[2+3*p], log_addr[2+3*p]}, {2'd1, pa});
            chk(log_op[3+3*p] == 2'd0 && log_addr[3+3*p] == pa, "R2 verify order",
                {log_op[3+3*p], log_addr[3+3*p]}, {2'd0, pa});
            chk(mem[pa] == FILL, "R2 content overwritten", mem[pa], FILL);
        end
        wipe_req = 1'b0;
        @(negedge clk);
        sw_req = 1'b1; sw_op = 2'd0; sw_addr = 8'h40;
        #1;
        chk(sw_gnt == 1'b0, "R4 no grant after wipe", sw_gnt, 0);
        @(negedge clk);
        chk(sw_deny == 1'b1 && fl_req == 1'b0, "R4 deny without command", {sw_deny, fl_req}, 2'b10);
        sw_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(wipe_ack == 1'b1 && log_n == 1 + 3 * NUM_PAGES, "R3 ack held, port quiet", {wipe_ack, 8'(log_n)}, {1'b1, 8'(1 + 3 * NUM_PAGES)});

        // R7: reset releases the lockout; wiped data persists
        do_reset();
        chk(wipe_ack == 1'b0 && fatal_err == 1'b0, "R7 cleared", {wipe_ack, fatal_err}, 0);
        sw_cmd(2'd0, 8'h10, 16'h0, rd, er);
        chk(rd == FILL && er == 1'b0, "R7 sw access after reset", rd, FILL);

        // R5: program fault during wipe
        do_reset();
        prog_fault = 1'b1;
        @(negedge clk);
        wipe_req = 1'b1;
        wait_end();
        chk(fatal_err == 1'b1 && wipe_ack == 1'b0, "R5 fatal on program fault", {fatal_err, wipe_ack}, 2'b10);
        chk(log_n == 2, "R5 stop after fault", log_n, 2);
        repeat (20) @(negedge clk);
        chk(fatal_err == 1'b1 && fl_req == 1'b0 && log_n == 2 && wipe_ack == 1'b0, "R5 terminal",
            {fatal_err, fl_req, wipe_ack, 8'(log_n)}, {3'b100, 8'd2});
        prog_fault = 1'b0;
        wipe_req = 1'b0;

        // R6: readback mismatch during wipe
        do_reset();
        bad_read = 1'b1;
        @(negedge clk);
        wipe_req = 1'b1;
        wait_end();
        chk(fatal_err == 1'b1 && wipe_ack == 1'b0, "R6 fatal on mismatch", {fatal_err, wipe_ack}, 2'b10);
        chk(log_n == 3, "R6 stop after verify", log_n, 3);
        bad_read = 1'b0;
        wipe_req = 1'b0;

        // R4: software and wipe requests in the same cycle
        do_reset();
        @(negedge clk);
        sw_req = 1'b1; sw_op = 2'd1; sw_addr = 8'h50; sw_wdata = 16'h0000;
        wipe_req = 1'b1;
        #1;
        chk(sw_gnt == 1'b0, "R4 wipe wins tie", sw_gnt, 0);
        @(negedge clk);
        sw_req = 1'b0;
        wait_end();
        chk(wipe_ack == 1'b1 && mem[8'h50] == 16'h5A50, "R4 tied sw op never ran",
            {wipe_ack, mem[8'h50]}, {1'b1, 16'h5A50});
        wipe_req = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule